// File: doc/BRIEF.md
# Fall-Through Word FIFO with Strobe Handshake

This block is a first-in first-out store of 16 words, 4 bits each. It is built as a chain of single-word cells rather than a RAM with pointers. A word enters at cell 0 and steps one cell per clock toward the last cell whenever the cell ahead is vacant. A vacancy made by a read travels the other way, one cell per clock, until it reaches the entry cell.

The writer watches `in_ready`. While it is high, the writer raises `si` with a word on `din`, and that word is captured. `si` has to drop again before another word can be taken. The reader watches `out_ready`. While it is high, `dout` carries the oldest word, and a rising `so` removes that word. A write raised while the store is full is held as pending for as long as `si` stays high. It completes when a vacancy reaches the entry cell.

Top module: `ft_fifo`

## Requirements
- R1: Words leave on `dout` in the order they were accepted, and up to 16 words of 4 bits are held at once.
- R2: When `in_ready` is high, a rising `si` (low at the previous clock edge, high at this one) captures `din` into the entry cell at that clock edge.
- R3: On the clock after a word is captured, `in_ready` is low. It goes high again one clock later if the second cell was vacant.
- R4: One high level of `si` captures at most one word, however long it is held. `si` must be seen low before the next capture.
- R5: While the store holds 16 words, `in_ready` stays low and a write attempt moves no data.
- R6: If `si` is still high from an attempt made while full, the pending word is captured on the first clock where `in_ready` is high. `in_ready` is low again on the next clock.
- R7: A rising `so` while `out_ready` is high removes the word on `dout`. `out_ready` is low on the next clock. Holding `so` high removes only one word. A rising `so` while `out_ready` is low has no effect.
- R8: After a removal from a full store, the vacancy reaches the entry cell 15 clocks later, and `in_ready` goes high then.
- R9: A word captured into an empty store shows on `dout` with `out_ready` high 15 clocks after capture. It advances one cell per clock.
- R10: A synchronous active-high `rst` vacates every cell. After reset, `in_ready` is high and `out_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| si | input | 1 | Write strobe, acts on its rising level |
| din | input | 4 | Word to write |
| in_ready | output | 1 | Entry cell vacant, a word can be taken |
| so | input | 1 | Read strobe, acts on its rising level |
| dout | output | 4 | Oldest word, valid while out_ready is high |
| out_ready | output | 1 | Last cell holds a valid word |

## Verification
A cell whose occupancy bit is wrong shows up at the ports in one of three ways. A word is duplicated or lost, which shows as the scoreboard's data order breaking when the store drains. A vacancy stalls, which shows as `in_ready` not rising on the 15th clock after a read from a full store. A word stalls, which shows as `out_ready` missing the 15-clock arrival. A faulty strobe edge detector shows within one clock as a second capture or removal while a strobe is held high. A wrong flag update right after a transfer is caught by the flag checks on the very next clock.

// File: rtl/ft_fifo_pkg.sv
package ft_fifo_pkg;

    localparam int FT_DEPTH = 16;
    localparam int FT_WIDTH = 4;

    // Write strobe tracking: idle (strobe seen low), waiting for room, done for this level
    typedef enum logic [1:0] {
        WR_IDLE = 2'd0,
        WR_WAIT = 2'd1,
        WR_DONE = 2'd2
    } wr_state_e;

    function automatic logic rising(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/ft_wr_ctrl.sv
module ft_wr_ctrl
    import ft_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic si,
    input  logic slot_free,
    output logic load
);

    wr_state_e state_q, state_d;

    always_comb begin
        load    = 1'b0;
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: begin
                if (si) begin
                    load    = slot_free;
                    state_d = slot_free ? WR_DONE : WR_WAIT;
                end
            end
            WR_WAIT: begin
                if (!si) begin
                    state_d = WR_IDLE;
                end else if (slot_free) begin
                    load    = 1'b1;
                    state_d = WR_DONE;
                end
            end
            WR_DONE: begin
                if (!si) state_d = WR_IDLE;
            end
            default: state_d = WR_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= WR_IDLE;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/ft_rd_ctrl.sv
module ft_rd_ctrl
    import ft_fifo_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic so,
    input  logic head_valid,
    output logic pop
);

    logic so_q;

    always_ff @(posedge clk) begin
        if (rst) so_q <= 1'b0;
        else     so_q <= so;
    end

    assign pop = rising(so, so_q) & head_valid;

endmodule

// File: rtl/ft_cell.sv
module ft_cell #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give,
    input  logic [WIDTH-1:0] d_in,
    output logic             full,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            full <= 1'b0;
            q    <= '0;
        end else if (take) begin
            full <= 1'b1;
            q    <= d_in;
        end else if (give) begin
            full <= 1'b0;
        end
    end

endmodule

// File: rtl/ft_fifo.sv
module ft_fifo
    import ft_fifo_pkg::*;
#(
    parameter int DEPTH = FT_DEPTH,
    parameter int WIDTH = FT_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             si,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             so,
    output logic [WIDTH-1:0] dout,
    output logic             out_ready
);

    localparam int LAST = DEPTH - 1;

    logic [DEPTH-1:0] occ;
    logic [DEPTH-1:0] take;
    logic [DEPTH-1:0] give;
    logic [WIDTH-1:0] word [DEPTH];
    logic             wr_load;
    logic             rd_pop;

    ft_wr_ctrl u_wr (
        .clk       (clk),
        .rst       (rst),
        .si        (si),
        .slot_free (~occ[0]),
        .load      (wr_load)
    );

    ft_rd_ctrl u_rd (
        .clk        (clk),
        .rst        (rst),
        .so         (so),
        .head_valid (occ[LAST]),
        .pop        (rd_pop)
    );

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        logic [WIDTH-1:0] feed;
        if (g == 0) begin : g_entry
            assign take[g] = wr_load;
            assign feed    = din;
        end else begin : g_inner
            assign take[g] = occ[g-1] & ~occ[g];
            assign feed    = word[g-1];
        end
        if (g == LAST) begin : g_head
            assign give[g] = rd_pop;
        end else begin : g_body
            assign give[g] = occ[g] & ~occ[g+1];
        end

        ft_cell #(.WIDTH(WIDTH)) u_cell (
            .clk  (clk),
            .rst  (rst),
            .take (take[g]),
            .give (give[g]),
            .d_in (feed),
            .full (occ[g]),
            .q    (word[g])
        );
    end

    assign in_ready  = ~occ[0];
    assign out_ready = occ[LAST];
    assign dout      = word[LAST];

endmodule

// File: rtl/ft_fifo_chk.sv
module ft_fifo_chk #(
    parameter int DEPTH = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             si,
    input logic             so,
    input logic             in_ready,
    input logic             out_ready,
    input logic [DEPTH-1:0] occ,
    input logic             load,
    input logic             pop
);

    a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        load |=> !in_ready);

    a_r3_free_again: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !occ[1]) |=> in_ready);

    a_r4_single_load: assert property (@(posedge clk) disable iff (rst)
        (load && si) ##1 si ##1 si |-> !load);

    a_r5_full_no_gain: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> ($countones(occ) <= $past($countones(occ))));

    a_r7_out_low_after_pop: assert property (@(posedge clk) disable iff (rst)
        pop |=> !out_ready);

    a_r7_single_pop: assert property (@(posedge clk) disable iff (rst)
        pop ##1 so ##1 so |-> !pop);

    a_r9_advance: assert property (@(posedge clk) disable iff (rst)
        (occ[0] && !occ[1]) |=> occ[1]);

    a_r10_reset_flags: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (in_ready && !out_ready));

endmodule

bind ft_fifo ft_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .si        (si),
    .so        (so),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .occ       (occ),
    .load      (wr_load),
    .pop       (rd_pop)
);

// File: tb/ft_fifo_test.sv
module ft_fifo_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       si  = 1'b0;
    logic       so  = 1'b0;
    logic [3:0] din = 4'd0;
    logic       in_ready;
    logic       out_ready;
    logic [3:0] dout;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q [$];

    always #10 clk = ~clk;

    ft_fifo uut (
        .clk       (clk),
        .rst       (rst),
        .si        (si),
        .din       (din),
        .in_ready  (in_ready),
        .so        (so),
        .dout      (dout),
        .out_ready (out_ready)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // driver: waits for room, strobes one word, records it as expected
    task automatic push_word(input logic [3:0] w);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        din = w;
        si  = 1'b1;
        @(posedge clk);
        exp_q.push_back(w);
        @(negedge clk);
        check("R3 busy after capture", in_ready, 0);
        si = 1'b0;
    endtask

    // monitor: waits for a word, compares with scoreboard, removes it
    task automatic pop_word(input string req);
        logic [3:0] e;
        @(negedge clk);
        while (!out_ready) @(negedge clk);
        if (exp_q.size() == 0) begin
            check({req, " unexpected word"}, 1, 0);
        end else begin
            e = exp_q.pop_front();
            check(req, dout, e);
        end
        so = 1'b1;
        @(negedge clk);
        so = 1'b0;
        check("R7 out_ready low after removal", out_ready, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int cnt;
        logic [3:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R10 in_ready after reset", in_ready, 1);
        check("R10 out_ready after reset", out_ready, 0);

        // R2/R3/R9: single word into empty store
        din = 4'd5;
        si  = 1'b1;
        @(posedge clk);
        exp_q.push_back(4'd5);
        @(negedge clk);
        check("R3 busy after capture", in_ready, 0);
        si = 1'b0;
        @(negedge clk);
        check("R3 ready one clock later", in_ready, 1);
        cnt = 1;
        while (!out_ready && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        check("R9 fall-through latency", cnt, 15);
        check("R2 captured word on dout", dout, 5);
        pop_word("R1 order");

        // R7: read strobe on empty store is ignored
        so = 1'b1;
        @(negedge clk);
        so = 1'b0;
        @(negedge clk);
        check("R7 empty read out_ready", out_ready, 0);
        check("R7 empty read in_ready", in_ready, 1);

        // R4: si held high long captures one word only
        din = 4'd9;
        si  = 1'b1;
        @(posedge clk);
        exp_q.push_back(4'd9);
        repeat (12) @(negedge clk);
        si = 1'b0;
        repeat (25) @(negedge clk);
        check("R4 held write word present", out_ready, 1);
        check("R4 held write word value", dout, 9);
        pop_word("R4 held write");
        repeat (25) @(negedge clk);
        check("R4 no second word", out_ready, 0);

        // R1/R5: fill all 16 cells
        for (int i = 0; i < 16; i++) push_word(4'((i * 7 + 3) & 15));
        repeat (20) @(negedge clk);
        check("R5 full in_ready low", in_ready, 0);
        check("R1 full out_ready", out_ready, 1);

        // R5/R6/R8: write attempt while full stays pending
        din = 4'hC;
        si  = 1'b1;
        repeat (6) @(negedge clk);
        check("R5 attempt while full in_ready", in_ready, 0);
        exp_q.push_back(4'hC);
        pop_word("R1 order full");
        cnt = 0;
        while (!in_ready && cnt < 40) begin
            @(negedge clk);
            cnt++;
        end
        check("R8 vacancy travel time", cnt, 15);
        @(negedge clk);
        check("R6 pending captured in_ready low", in_ready, 0);
        si = 1'b0;
        repeat (20) @(negedge clk);
        check("R6 full again", in_ready, 0);

        // R1: drain 16 words, pending word last
        for (int i = 0; i < 16; i++) pop_word("R1 drain order");
        check("R1 scoreboard empty", exp_q.size(), 0);

        // R7: held read strobe removes one word
        push_word(4'd3);
        push_word(4'd6);
        @(negedge clk);
        while (!out_ready) @(negedge clk);
        e = exp_q.pop_front();
        check("R7 first word", dout, e);
        so = 1'b1;
        repeat (30) @(negedge clk);
        check("R7 held read leaves next word", out_ready, 1);
        check("R7 held read next value", dout, 6);
        so = 1'b0;
        @(negedge clk);
        pop_word("R7 after held read");
        check("R1 scoreboard empty at end", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule